// File: doc/BRIEF.md
# Power-on Reset Sequencing Controller

This block produces the internal reset of a small microcontroller. A power-on pulse from an analog detector sets a reset latch and clears a delay timer. The timer counts free-running clock cycles only while the effective master clear is high. When it reaches its terminal count, it clears the latch and the internal reset is released. The terminal count is a parameter. The default is 18000 cycles, about 18 ms with a 1 MHz clock.

A configuration input selects the source of the effective master clear:

- When it is high (unprogrammed), the external pin drives reset through a two-flop synchronizer.
- When it is low (programmed), master clear is tied high inside the block, and the pin is reported as a general-purpose input.

A low on the effective master clear at any time sends the chip back into reset and restarts the timer. After expiry the timer saturates, so the reset stays released until the next power-on or master-clear event.

Top module: `porseq_top`

## Requirements
- R1: `chipRst` goes high asynchronously the moment `porPulse` goes high. It stays high for as long as `porPulse` is high, and it is still high right after `porPulse` falls.
- R2: With `cfgExtMclr`=0 (internal master clear), `chipRst` falls at exactly the DELAY-th rising clock edge after `porPulse` is low. It is still high after edge DELAY-1.
- R3: With `cfgExtMclr`=1 (pin master clear), `chipRst` falls at exactly the (DELAY+2)-th rising edge after `mclrPin` rises. The two extra edges come from the synchronizer. If the pin is already high when `porPulse` falls, the count starts from the fall of `porPulse`.
- R4: With `cfgExtMclr`=1 and reset released, a low on `mclrPin` lasting at least one clock period re-asserts `chipRst` at the third rising edge after the pin falls. `chipRst` is still low after the second edge.
- R5: After a master-clear low of any length, the timer restarts from zero. `chipRst` is released DELAY+2 edges after the pin returns high.
- R6: `pinIsGpio` equals the inverse of `cfgExtMclr`. With `cfgExtMclr`=0, activity on `mclrPin` has no effect on `chipRst`.
- R7: Once released, `chipRst` stays low for any number of cycles, including beyond the timer's natural wrap point, while the effective master clear stays high.
- R8: With `cfgExtMclr`=1 and `mclrPin` held low, `chipRst` stays high indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timer clock |
| porPulse | input | 1 | Power-on pulse from the analog detector, active high, asynchronous |
| mclrPin | input | 1 | External master-clear pin, active low, asynchronous |
| cfgExtMclr | input | 1 | 1 = the pin drives master clear; 0 = master clear is tied high internally |
| chipRst | output | 1 | Internal chip reset, active high |
| pinIsGpio | output | 1 | High when the master-clear pin is free for general-purpose input |

## Verification
The release delay is measured edge by edge in both configurations. Power-on with the pin already high separates the synchronizer latency from the timer period, and power-up with the pin held low shows that the count starts only when the pin rises. Random master-clear low pulses of one to eight cycles, at random times and in random modes, check the three-edge re-entry and the full restart of the timer, which shows that no partial count survives. Long idle stretches past the counter's wrap point, and pin toggling in internal mode, separate a saturating timer from a wrapping one and show that the pin is really ignored when freed.

// File: rtl/porseq_pkg.sv
package porseq_pkg;
  // Strobes from the control to the delay-timer datapath
  typedef struct packed {
    logic clear;  // force the count to zero
    logic count;  // advance the count by one
  } tmrStrobe_t;
endpackage

// File: rtl/porseq_sync.sv
module porseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstAsync,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shift;

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) shift <= '0;
    else          shift <= {shift[STAGES-2:0], din};
  end

  assign dout = shift[STAGES-1];
endmodule

// File: rtl/porseq_timer.sv
module porseq_timer
  import porseq_pkg::*;
#(
  parameter int unsigned DELAY = 18000
) (
  input  logic       clk,
  input  logic       porPulse,
  input  tmrStrobe_t strb,
  output logic       atLast,
  output logic       sat
);
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DELAY);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse)        cnt <= '0;
    else if (strb.clear) cnt <= '0;
    else if (strb.count) cnt <= cnt + 1'b1;
  end

  assign atLast = (cnt == LAST);
  assign sat    = (cnt == FULL);

  // R7: a saturated count holds until cleared
  a_r7_saturate: assert property (@(posedge clk) disable iff (porPulse)
    (sat && !strb.clear) |=> sat);

  // R2: without a strobe the count does not move
  a_r2_idle: assert property (@(posedge clk) disable iff (porPulse)
    (!strb.count && !strb.clear) |=> $stable(cnt));
endmodule

// File: rtl/porseq_ctrl.sv
module porseq_ctrl
  import porseq_pkg::*;
(
  input  logic       clk,
  input  logic       porPulse,
  input  logic       mclrSync,
  input  logic       cfgExtMclr,
  input  logic       atLast,
  input  logic       sat,
  output tmrStrobe_t strb,
  output logic       chipRst,
  output logic       pinIsGpio
);
  logic effMclr;
  logic rstLatch;

  assign effMclr   = cfgExtMclr ? mclrSync : 1'b1;
  assign pinIsGpio = ~cfgExtMclr;

  always_comb begin
    strb.clear = ~effMclr;
    strb.count = effMclr & ~sat;
  end

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse)                    rstLatch <= 1'b1;
    else if (!effMclr)               rstLatch <= 1'b1;
    else if (strb.count && atLast)   rstLatch <= 1'b0;
  end

  assign chipRst = rstLatch | porPulse;

  // R1: latch still set when the power-on pulse ends
  a_r1_hold: assert property (@(posedge clk) $fell(porPulse) |-> rstLatch);

  // R4: a low effective master clear sets the latch on the next edge
  a_r4_reenter: assert property (@(posedge clk) disable iff (porPulse)
    !effMclr |=> rstLatch);

  // R3: release only on the terminal count with master clear high
  a_r3_release: assert property (@(posedge clk) disable iff (porPulse)
    $fell(rstLatch) |-> $past(effMclr && atLast));
endmodule

// File: rtl/porseq_top.sv
module porseq_top
  import porseq_pkg::*;
#(
  parameter int unsigned DELAY = 18000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porPulse,
  input  logic mclrPin,
  input  logic cfgExtMclr,
  output logic chipRst,
  output logic pinIsGpio
);
  logic       mclrSync;
  logic       atLast;
  logic       sat;
  tmrStrobe_t strb;

  porseq_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstAsync(porPulse), .din(mclrPin), .dout(mclrSync)
  );

  porseq_ctrl uCtrl (
    .clk(clk), .porPulse(porPulse), .mclrSync(mclrSync),
    .cfgExtMclr(cfgExtMclr), .atLast(atLast), .sat(sat),
    .strb(strb), .chipRst(chipRst), .pinIsGpio(pinIsGpio)
  );

  porseq_timer #(.DELAY(DELAY)) uTimer (
    .clk(clk), .porPulse(porPulse), .strb(strb),
    .atLast(atLast), .sat(sat)
  );
endmodule

// File: tb/sim_porseq_top.sv
`timescale 1ns/1ps
module sim_porseq_top;
  localparam int DLY = 12;

  logic clk = 1'b0;
  logic porPulse, mclrPin, cfgExtMclr;
  logic chipRst, pinIsGpio;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  porseq_top #(.DELAY(DLY)) u0 (
    .clk(clk), .porPulse(porPulse), .mclrPin(mclrPin),
    .cfgExtMclr(cfgExtMclr), .chipRst(chipRst), .pinIsGpio(pinIsGpio)
  );

  function automatic int expRelease(bit extMode);
    return extMode ? DLY + 2 : DLY;
  endfunction

  function automatic int expReassert();
    return 3;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count n rising edges, then sit at the following falling edge
  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  // step edge by edge; check chipRst high through edge n-1 and low at edge n
  task automatic expectRelease(int n, string req);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == n - 1) check(chipRst == 1'b1, req, chipRst, 1);
      if (k == n)     check(chipRst == 1'b0, req, chipRst, 0);
    end
  endtask

  task automatic powerOn(bit extMode, bit pinLevel);
    @(negedge clk);
    cfgExtMclr = extMode;
    mclrPin = pinLevel;
    porPulse = 1'b1;
    #1;
    check(chipRst == 1'b1, "R1 async assert", chipRst, 1);
    edges(3);
    check(chipRst == 1'b1, "R1 hold", chipRst, 1);
    porPulse = 1'b0;
  endtask

  initial begin
    porPulse = 1'b0;
    mclrPin = 1'b1;
    cfgExtMclr = 1'b1;
    void'($urandom(32'd4711));
    edges(2);

    // R2: internal mode release
    powerOn(1'b0, 1'b0);
    check(pinIsGpio == 1'b1, "R6 gpio flag internal", pinIsGpio, 1);
    expectRelease(expRelease(1'b0), "R2 internal release");

    // R6: pin activity ignored in internal mode
    for (int i = 0; i < 20; i++) begin
      mclrPin = 1'(($urandom % 2));
      edges(1 + ($urandom % 3));
      check(chipRst == 1'b0, "R6 pin ignored", chipRst, 0);
    end

    // R7: saturation well past counter wrap
    edges(3 * DLY + 20);
    check(chipRst == 1'b0, "R7 no wrap internal", chipRst, 0);

    // R3: external mode, pin already high
    powerOn(1'b1, 1'b1);
    check(pinIsGpio == 1'b0, "R6 gpio flag external", pinIsGpio, 0);
    expectRelease(expRelease(1'b1), "R3 pin high at power-on");

    // R8 then R3: pin held low during power-up
    powerOn(1'b1, 1'b0);
    edges(5 * DLY);
    check(chipRst == 1'b1, "R8 held by low pin", chipRst, 1);
    mclrPin = 1'b1;
    expectRelease(expRelease(1'b1), "R3 release after pin rise");
    edges(3 * DLY + 20);
    check(chipRst == 1'b0, "R7 no wrap external", chipRst, 0);

    // R4 / R5: random master-clear pulses, randomly mixed with internal-mode runs
    for (int t = 0; t < 30; t++) begin
      bit extMode;
      int lowLen;
      extMode = 1'(($urandom % 4) != 0);
      lowLen = 1 + int'($urandom % 8);
      powerOn(extMode, 1'b1);
      expectRelease(expRelease(extMode), extMode ? "R3 random run" : "R2 random run");
      edges(int'($urandom % 10));
      mclrPin = 1'b0;
      for (int k = 1; k <= lowLen; k++) begin
        @(negedge clk);
        if (extMode && k == expReassert() - 1)
          check(chipRst == 1'b0, "R4 not yet reasserted", chipRst, 0);
        if (extMode && k == expReassert())
          check(chipRst == 1'b1, "R4 reassert", chipRst, 1);
        if (!extMode)
          check(chipRst == 1'b0, "R6 low pin ignored", chipRst, 0);
      end
      mclrPin = 1'b1;
      if (extMode) begin
        if (lowLen < expReassert()) begin
          edges(expReassert() - lowLen);
          check(chipRst == 1'b1, "R4 reassert short pulse", chipRst, 1);
          expectRelease(expRelease(1'b1) - (expReassert() - lowLen), "R5 restart");
        end else begin
          expectRelease(expRelease(1'b1), "R5 restart");
        end
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule